// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins two parallel ports, called A and B, through two independent non-inverting data paths: A to B and B to A. Each path has one storage element with three modes. When its latch-enable is high, the element is transparent: the output follows the input in the same cycle and the storage takes the input value on every cycle. When latch-enable is low, the element holds its value and loads a new one only on a rising transition of its own strobe input. A rising transition counts only while the path's active-low clock enable is low.

The strobe is an ordinary data-rate signal. The block samples it with the system clock, so a rising transition is the cycle in which the strobe is high after being low at the previous clock edge. Each path drives its destination port only while its active-low output enable is low. Otherwise the drive qualifier is low, and the surrounding pad or bus logic treats this as high impedance. The output enable acts only on the drive qualifier and never touches the stored data. A synchronous active-high reset clears both storage elements and forces both drive qualifiers low.

Top module: `ubt_xcvr`

## Requirements
- R1: While a path's latch-enable is high, its output equals its input in the same cycle. When latch-enable falls, the output keeps the input value that was present at the last clock edge with latch-enable high.
- R2: While latch-enable is low and the strobe stays at a constant level, either high or low, the output keeps its stored value whatever the input does.
- R3: With latch-enable low and clock enable low, a strobe that is low at one clock edge and high at the next loads the input present at that second edge. The output shows the new value right after that edge.
- R4: A path's drive qualifier (b_drv for A to B, a_drv for B to A) is 1 exactly when its output enable is 0 and reset is not asserted.
- R5: While clock enable is high, strobe rising transitions leave the stored value unchanged.
- R6: The stored value keeps updating while the drive qualifier is 0. When the output is enabled again, it shows the value captured while it was disabled.
- R7: The B-to-A path behaves like the A-to-B path with its own controls (ba_le, ba_cp, ba_ce_n, ba_oe_n), and activity on one path does not change the other path's output.
- R8: A clock edge with rst high clears both stored values to zero, and both drive qualifiers are 0 while rst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data presented to port A (B-to-A path) |
| a_drv | output | 1 | Drive qualifier for port A; 0 means high impedance |
| b_in | input | W | Data arriving on port B |
| b_out | output | W | Data presented to port B (A-to-B path) |
| b_drv | output | 1 | Drive qualifier for port B; 0 means high impedance |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_cp | input | 1 | A-to-B strobe, loads on a rising transition |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_cp | input | 1 | B-to-A strobe, loads on a rising transition |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Assertions inside each storage instance check every cycle that the stored value tracks the input while transparent, stays put when there is no qualified strobe edge, loads on a qualified edge, ignores edges while clock enable is high, and clears on reset. Only the bench scenarios can show that the ports behave as intended end to end. These include the same-cycle transparent path, the value kept when latch-enable falls, the drive qualifier following the output enable, storage updating while the output is disabled, and the two directions staying independent.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned UBT_W_DEFAULT = 18;

    // Per-direction control bundle
    typedef struct packed {
        logic le;     // 1 = transparent
        logic cp;     // strobe, loads on rising transition
        logic ce_n;   // strobe qualifier, active low
        logic oe_n;   // output drive, active low
    } ubt_ctrl_t;

    function automatic logic ubt_is_rise(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/ubt_edge.sv
module ubt_edge (
    input  logic clk,
    input  logic strobe,
    output logic rise
);
    import ubt_pkg::*;

    logic strobe_q;

    // Tracks the strobe level even during reset, so that releasing reset
    // with the strobe already high does not create a false edge.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    assign rise = ubt_is_rise(strobe, strobe_q);

endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
    parameter int unsigned W = ubt_pkg::UBT_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  ubt_pkg::ubt_ctrl_t ctrl,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic             drive
);
    logic         rise;
    logic [W-1:0] q;
    logic         load_edge;

    ubt_edge edge_i (
        .clk    (clk),
        .strobe (ctrl.cp),
        .rise   (rise)
    );

    assign load_edge = rise & ~ctrl.ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ctrl.le) begin
            q <= din;
        end else if (load_edge) begin
            q <= din;
        end
    end

    assign dout  = ctrl.le ? din : q;
    assign drive = ~ctrl.oe_n & ~rst;

    // R1: transparent mode keeps storage tracking the input
    p_track_r1: assert property (@(posedge clk) disable iff (rst)
        ctrl.le |=> q == $past(din));

    // R2: no qualified edge while closed, value held
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.le && !rise) |=> $stable(q));

    // R3: qualified rising strobe captures input
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.le && rise && !ctrl.ce_n) |=> q == $past(din));

    // R5: disabled clock enable suppresses the edge
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.le && rise && ctrl.ce_n) |=> $stable(q));

    // R8: reset clears storage
    p_clear_r8: assert property (@(posedge clk)
        rst |=> q == '0);

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int unsigned W = ubt_pkg::UBT_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic         ab_le,
    input  logic         ab_cp,
    input  logic         ab_ce_n,
    input  logic         ab_oe_n,
    input  logic         ba_le,
    input  logic         ba_cp,
    input  logic         ba_ce_n,
    input  logic         ba_oe_n
);
    import ubt_pkg::*;

    localparam int unsigned NDIR = 2;

    ubt_ctrl_t    ctrl [NDIR];
    logic [W-1:0] src  [NDIR];
    logic [W-1:0] dst  [NDIR];
    logic         drv  [NDIR];

    // Index 0: A to B, index 1: B to A
    assign ctrl[0] = '{le: ab_le, cp: ab_cp, ce_n: ab_ce_n, oe_n: ab_oe_n};
    assign ctrl[1] = '{le: ba_le, cp: ba_cp, ce_n: ba_ce_n, oe_n: ba_oe_n};
    assign src[0]  = a_in;
    assign src[1]  = b_in;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        ubt_store #(.W(W)) store_i (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctrl[d]),
            .din   (src[d]),
            .dout  (dst[d]),
            .drive (drv[d])
        );
    end

    assign b_out = dst[0];
    assign b_drv = drv[0];
    assign a_out = dst[1];
    assign a_drv = drv[1];

endmodule

// File: tb/ubt_xcvr_tb.sv
module ubt_xcvr_tb_top;
    localparam int W = 18;

    typedef struct {
        bit          dir;   // 0: check port B (A->B), 1: check port A
        bit          oe;
        logic [W-1:0] data;
        string       tag;
    } item_t;

    logic clk = 0;
    logic rst = 1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_drv, b_drv;
    logic ab_le = 0, ab_cp = 0, ab_ce_n = 1, ab_oe_n = 1;
    logic ba_le = 0, ba_cp = 0, ba_ce_n = 1, ba_oe_n = 1;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    item_t sb[$];

    always #10 clk = ~clk;

    ubt_xcvr #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .ab_le(ab_le), .ab_cp(ab_cp), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
        .ba_le(ba_le), .ba_cp(ba_cp), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n)
    );

    // Monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic got_oe;
            logic [W-1:0] got_d;
            it = sb.pop_front();
            got_oe = it.dir ? a_drv : b_drv;
            got_d  = it.dir ? a_out : b_out;
            n_vec++;
            if (got_oe !== it.oe || (it.oe && got_d !== it.data)) begin
                n_bad++;
                $display("FAIL %s dir=%0d: drv=%b data=%h, expected drv=%b data=%h",
                         it.tag, it.dir, got_oe, got_d, it.oe, it.data);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input bit dir, input bit oe, input logic [W-1:0] d,
                              input string tag);
        item_t it;
        it.dir = dir; it.oe = oe; it.data = d; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    initial begin
        repeat (3) tick();
        // R8: drive qualifiers low in reset
        expect_out(0, 0, '0, "R8 reset drv");
        expect_out(1, 0, '0, "R8 reset drv");
        settle();
        a_in = 18'h01234; b_in = 18'h04321;
        rst = 0; ab_oe_n = 0; ba_oe_n = 0;
        tick();
        expect_out(0, 1, '0, "R8 cleared");
        expect_out(1, 1, '0, "R8 cleared");
        settle();

        // R1 transparent
        ab_le = 1; a_in = 18'h2AAAA;
        tick(); expect_out(0, 1, 18'h2AAAA, "R1 transparent"); settle();
        a_in = 18'h15555;
        tick(); expect_out(0, 1, 18'h15555, "R1 transparent"); settle();
        ab_le = 0;
        tick(); settle();
        a_in = 18'h3FFFF;
        tick(); expect_out(0, 1, 18'h15555, "R1 close hold"); settle();

        // R3 capture
        ab_ce_n = 0; a_in = 18'h0ABCD; ab_cp = 1;
        tick(); expect_out(0, 1, 18'h0ABCD, "R3 capture"); settle();
        // R2 strobe held high
        a_in = 18'h31313;
        tick(); tick(); expect_out(0, 1, 18'h0ABCD, "R2 static high"); settle();
        // R2 strobe held low
        ab_cp = 0; a_in = 18'h22222;
        tick(); tick(); expect_out(0, 1, 18'h0ABCD, "R2 static low"); settle();
        ab_cp = 1; a_in = 18'h00F0F;
        tick(); expect_out(0, 1, 18'h00F0F, "R3 capture 2"); settle();

        // R5 gated edge
        ab_ce_n = 1; ab_cp = 0;
        tick(); settle();
        a_in = 18'h3C3C3; ab_cp = 1;
        tick(); expect_out(0, 1, 18'h00F0F, "R5 edge ignored"); settle();
        ab_cp = 0;
        tick(); settle();

        // R4 output disable
        ab_oe_n = 1;
        tick(); expect_out(0, 0, '0, "R4 hi-z"); settle();
        // R6 storage updates while disabled
        ab_ce_n = 0; a_in = 18'h1E1E1; ab_cp = 1;
        tick(); expect_out(0, 0, '0, "R4 hi-z"); settle();
        ab_cp = 0; ab_oe_n = 0; a_in = '0;
        tick(); expect_out(0, 1, 18'h1E1E1, "R6 captured under hi-z"); settle();

        // R7 B-to-A path
        ba_le = 1; b_in = 18'h2F0F0;
        tick();
        expect_out(1, 1, 18'h2F0F0, "R7 transparent");
        expect_out(0, 1, 18'h1E1E1, "R7 independence");
        settle();
        ba_le = 0;
        tick(); settle();
        b_in = 18'h11111;
        tick(); expect_out(1, 1, 18'h2F0F0, "R7 hold"); settle();
        ba_ce_n = 0; ba_cp = 1;
        tick(); expect_out(1, 1, 18'h11111, "R7 capture"); settle();
        ba_ce_n = 1; ba_cp = 0;
        tick(); settle();
        b_in = 18'h33333; ba_cp = 1;
        tick(); expect_out(1, 1, 18'h11111, "R7 gated edge"); settle();
        ba_oe_n = 1;
        tick();
        expect_out(1, 0, '0, "R7 hi-z");
        expect_out(0, 1, 18'h1E1E1, "R7 independence");
        settle();

        // R8 reset while running
        rst = 1;
        tick();
        expect_out(0, 0, '0, "R8 drv in reset");
        expect_out(1, 0, '0, "R8 drv in reset");
        settle();
        rst = 0; ba_oe_n = 0;
        tick();
        expect_out(0, 1, '0, "R8 storage cleared");
        expect_out(1, 1, '0, "R8 storage cleared");
        settle();

        @(negedge clk); #2;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule